// File: doc/BRIEF.md
# DMA Channel Flow Sequencer

This block is the control sequencer of a single DMA channel. Software programs a start address, a count, a next-descriptor pointer and a configuration word through a small register write port. Writing the configuration with its enable bit set launches the first work unit: the start address and count are copied into the current registers, and the data mover is told through a one-cycle load pulse. The data mover itself is outside this block. It reports the end of each work unit on a single done input.

A three-bit flow field in the active configuration picks the follow-up action. The channel can halt and wait for a new launch. It can reload the programmed parameters in a circular fashion with no idle cycle, fetching no descriptors. It can read a back-to-back descriptor from an incrementing descriptor pointer. Or it can read a linked descriptor that supplies only the low half of the following pointer, with the upper half held so that the chain stays inside one 64K page. Descriptor words come in over a 16-bit request/acknowledge read port. When the fetch completes, the fetched configuration becomes the active one, so one chain can change modes from unit to unit. A completion interrupt can be enabled per configuration.

Top module: `dma_flow_seq`

## Requirements
- R1: After reset, run, irq, unit_load and mem_rd_req are low, and cur_addr and cur_count are zero.
- R2: Register selects are 0 configuration, 1 start address, 2 count (low 16 bits), and 3 next-descriptor pointer. Configuration bits are: bit 0 enable, bit 1 interrupt enable, bits 4:2 flow. A configuration write with enable set while idle loads cur_addr and cur_count from the start and count registers, raises run, and pulses unit_load, all in the following cycle.
- R3: irq is a one-cycle pulse in the cycle after a unit_done that is accepted while running. It occurs only when the active configuration's interrupt-enable bit is 1.
- R4: With flow 0 (stop), run falls in the cycle after unit_done. A halted channel ignores unit_done and restarts on a new configuration write with enable set.
- R5: With flow 1 (circular reload), the cycle after unit_done shows cur_addr and cur_count reloaded from the current start and count registers, with unit_load high and run still high. No memory read is made. A configuration write with enable clear drops run in the next cycle.
- R6: With flow 4 (array), unit_done starts a fetch of four 16-bit words in this order: start low, start high, configuration, count. The fetch address comes from a descriptor pointer that is loaded from the next-descriptor register at launch and advances by 2 per word, so each descriptor follows the previous one 8 bytes on.
- R7: With flow 6 (page-local list), unit_done starts a fetch of five words at the next-descriptor register: next-pointer low half first, then the four array words. The fetched low half replaces bits 15:0 of the register, and bits 31:16 keep their value.
- R8: When a fetch completes, the fetched configuration replaces the active one, flow included. If its enable bit is 1, cur_addr and cur_count take the fetched start and count, with unit_load high, in the next cycle. If it is 0, run falls and no load occurs.
- R9: mem_rd_req stays high with mem_rd_addr unchanged until mem_rd_ack is seen.
- R10: The reserved flow values 2, 3, 5 and 7 behave as stop.
- R11: A unit_done while the channel is idle produces no interrupt, no load and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (0 config, 1 start, 2 count, 3 next pointer) |
| reg_wr_data | input | 32 | Register write data |
| unit_done | input | 1 | Work unit finished, from the data mover |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested descriptor word |
| mem_rd_ack | input | 1 | Read data valid; accepts the request |
| mem_rd_data | input | 16 | Descriptor word |
| run | output | 1 | Channel running status |
| unit_load | output | 1 | One-cycle pulse: current registers hold a new work unit |
| cur_addr | output | 32 | Current start address |
| cur_count | output | 16 | Current count |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A corrupted flow decode or descriptor pointer shows up on the read port within one fetch. It appears as a read address that departs from the expected byte sequence, or as a change in the page half of a list chain, and the scoreboard compares every accepted address. A wrong field capture or a mode switch lost in the sequencer shows up at the next unit_load, one cycle after the fetch finishes, as a wrong cur_addr or cur_count. A stop or reload decision taken wrongly is visible on run and unit_load in the cycle directly after unit_done.

// File: rtl/dma_flow_pkg.sv
`timescale 1ns/1ps
package dma_flow_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 2 * WORD_W;
    localparam int FLOW_W = 3;
    localparam int SEL_W  = 2;
    localparam int SLOT_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_W / 8);

    // flow encodings
    localparam logic [FLOW_W-1:0] FLOW_STOP  = 3'h0;
    localparam logic [FLOW_W-1:0] FLOW_AUTO  = 3'h1;
    localparam logic [FLOW_W-1:0] FLOW_ARRAY = 3'h4;
    localparam logic [FLOW_W-1:0] FLOW_LIST  = 3'h6;

    // register selects
    localparam logic [SEL_W-1:0] SEL_CFG   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_START = 2'd1;
    localparam logic [SEL_W-1:0] SEL_COUNT = 2'd2;
    localparam logic [SEL_W-1:0] SEL_NEXT  = 2'd3;

    // descriptor word slots, in fetch order
    localparam logic [SLOT_W-1:0] SLOT_NDP = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_SLO = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_SHI = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_CFG = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_CNT = 3'd4;

    typedef struct packed {
        logic [FLOW_W-1:0] flow;
        logic              ien;
        logic              en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic              with_ndp;
        logic [WORD_W-1:0] ndp_lo;
        logic [ADDR_W-1:0] start;
        cfg_t              cfg;
        logic [WORD_W-1:0] count;
    } desc_t;

    typedef enum logic [1:0] {M_STOP, M_AUTO, M_ARRAY, M_LIST} mode_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FETCH} state_e;

    function automatic mode_e flow_mode(input logic [FLOW_W-1:0] f);
        case (f)
            FLOW_AUTO:  return M_AUTO;
            FLOW_ARRAY: return M_ARRAY;
            FLOW_LIST:  return M_LIST;
            default:    return M_STOP;   // stop and every reserved value
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] first_slot(input logic with_ndp);
        return with_ndp ? SLOT_NDP : SLOT_SLO;
    endfunction
endpackage

// File: rtl/dma_flow_regs.sv
`timescale 1ns/1ps
module dma_flow_regs
    import dma_flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              desc_load,
    input  desc_t             desc,
    output cfg_t              cfg,
    output logic [ADDR_W-1:0] start_addr,
    output logic [WORD_W-1:0] count,
    output logic [ADDR_W-1:0] next_ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            start_addr <= '0;
            count      <= '0;
            next_ptr   <= '0;
        end else begin
            if (desc_load) begin
                cfg        <= desc.cfg;
                start_addr <= desc.start;
                count      <= desc.count;
                if (desc.with_ndp)
                    next_ptr[WORD_W-1:0] <= desc.ndp_lo;
            end
            // software write takes precedence over a descriptor load
            if (wr_en) begin
                case (wr_sel)
                    SEL_CFG:   cfg        <= cfg_t'(wr_data[CFG_W-1:0]);
                    SEL_START: start_addr <= wr_data;
                    SEL_COUNT: count      <= wr_data[WORD_W-1:0];
                    default:   next_ptr   <= wr_data;
                endcase
            end
        end
    end

    // page half of the chain pointer survives a list fetch
    p_page_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (desc_load && desc.with_ndp && !(wr_en && wr_sel == SEL_NEXT))
        |=> (next_ptr[ADDR_W-1:WORD_W] == $past(next_ptr[ADDR_W-1:WORD_W])));
endmodule

// File: rtl/dma_flow_fetch.sv
`timescale 1ns/1ps
module dma_flow_fetch
    import dma_flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic              with_ndp,
    input  logic              mem_rd_ack,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              done,
    output desc_t             desc,
    output logic [ADDR_W-1:0] ptr_after
);
    logic              busy;
    logic [ADDR_W-1:0] ptr;
    logic [SLOT_W-1:0] slot;
    logic              last_word;

    assign last_word   = (slot == SLOT_CNT);
    assign mem_rd_req  = busy;
    assign mem_rd_addr = ptr;
    assign ptr_after   = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            ptr  <= '0;
            slot <= '0;
            desc <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy          <= 1'b1;
                ptr           <= start_ptr;
                slot          <= first_slot(with_ndp);
                desc.with_ndp <= with_ndp;
            end else if (busy && mem_rd_ack) begin
                ptr  <= ptr + ADDR_STEP;
                slot <= slot + 1'b1;
                case (slot)
                    SLOT_NDP: desc.ndp_lo                    <= mem_rd_data;
                    SLOT_SLO: desc.start[WORD_W-1:0]         <= mem_rd_data;
                    SLOT_SHI: desc.start[ADDR_W-1:WORD_W]    <= mem_rd_data;
                    SLOT_CFG: desc.cfg <= cfg_t'(mem_rd_data[CFG_W-1:0]);
                    SLOT_CNT: desc.count                     <= mem_rd_data;
                    default:  desc.count                     <= desc.count;
                endcase
                if (last_word) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    p_hold_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_ack && !abort)
        |=> (mem_rd_req && $stable(mem_rd_addr)));

    p_word_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_ack && !last_word && !abort)
        |=> (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + ADDR_STEP));
endmodule

// File: rtl/dma_flow_ctrl.sv
`timescale 1ns/1ps
module dma_flow_ctrl
    import dma_flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  cfg_t              cfg_wr_val,
    input  cfg_t              act_cfg,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] count,
    input  logic [ADDR_W-1:0] next_ptr,
    input  logic              unit_done,
    input  logic              fetch_done,
    input  logic [ADDR_W-1:0] fd_start,
    input  logic [WORD_W-1:0] fd_count,
    input  logic              fd_en,
    input  logic [ADDR_W-1:0] fetch_ptr_after,
    output logic              fetch_start,
    output logic              fetch_abort,
    output logic [ADDR_W-1:0] fetch_ptr,
    output logic              fetch_list,
    output logic              run,
    output logic              unit_load,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_count,
    output logic              irq
);
    state_e            state;
    mode_e             mode;
    logic [ADDR_W-1:0] cdp;      // current descriptor pointer
    logic              halt;
    logic              launch;
    logic              accept;

    assign mode        = flow_mode(act_cfg.flow);
    assign halt        = cfg_wr && !cfg_wr_val.en;
    assign launch      = cfg_wr && cfg_wr_val.en && (state == S_IDLE);
    assign accept      = unit_done && (state == S_RUN) && act_cfg.en && !halt;
    assign fetch_list  = (mode == M_LIST);
    assign fetch_start = accept && (mode == M_ARRAY || mode == M_LIST);
    assign fetch_ptr   = fetch_list ? next_ptr : cdp;
    assign fetch_abort = halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            run       <= 1'b0;
            irq       <= 1'b0;
            unit_load <= 1'b0;
            cur_addr  <= '0;
            cur_count <= '0;
            cdp       <= '0;
        end else begin
            irq       <= accept && act_cfg.ien;
            unit_load <= 1'b0;
            if (halt) begin
                state <= S_IDLE;
                run   <= 1'b0;
            end else begin
                case (state)
                    S_IDLE: begin
                        if (launch) begin
                            state     <= S_RUN;
                            run       <= 1'b1;
                            cur_addr  <= start_addr;
                            cur_count <= count;
                            cdp       <= next_ptr;
                            unit_load <= 1'b1;
                        end
                    end
                    S_RUN: begin
                        if (accept) begin
                            case (mode)
                                M_STOP: begin
                                    state <= S_IDLE;
                                    run   <= 1'b0;
                                end
                                M_AUTO: begin
                                    cur_addr  <= start_addr;
                                    cur_count <= count;
                                    unit_load <= 1'b1;
                                end
                                M_ARRAY: state <= S_FETCH;
                                M_LIST:  state <= S_FETCH;
                            endcase
                        end
                    end
                    S_FETCH: begin
                        if (fetch_done) begin
                            cdp <= fetch_ptr_after;
                            if (fd_en) begin
                                state     <= S_RUN;
                                cur_addr  <= fd_start;
                                cur_count <= fd_count;
                                unit_load <= 1'b1;
                            end else begin
                                state <= S_IDLE;
                                run   <= 1'b0;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(unit_done));

    p_stop_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && unit_done && mode == M_STOP && !cfg_wr) |=> !run);

    p_zero_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && unit_done && mode == M_AUTO && !cfg_wr)
        |=> (unit_load && run));

    p_halt_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_wr_val.en) |=> (!run && !unit_load));
endmodule

// File: rtl/dma_flow_seq.sv
`timescale 1ns/1ps
module dma_flow_seq
    import dma_flow_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_wr_sel,
    input  logic [31:0] reg_wr_data,
    input  logic        unit_done,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ack,
    input  logic [15:0] mem_rd_data,
    output logic        run,
    output logic        unit_load,
    output logic [31:0] cur_addr,
    output logic [15:0] cur_count,
    output logic        irq
);
    cfg_t              cfg_q;
    cfg_t              cfg_wr_val;
    logic              cfg_wr;
    logic [ADDR_W-1:0] start_q;
    logic [WORD_W-1:0] count_q;
    logic [ADDR_W-1:0] next_q;
    desc_t             fdesc;
    logic              fdone;
    logic              fstart;
    logic              fabort;
    logic              flist;
    logic [ADDR_W-1:0] fptr;
    logic [ADDR_W-1:0] fptr_after;

    assign cfg_wr     = reg_wr_en && (reg_wr_sel == SEL_CFG);
    assign cfg_wr_val = cfg_t'(reg_wr_data[CFG_W-1:0]);

    dma_flow_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_data    (reg_wr_data),
        .desc_load  (fdone),
        .desc       (fdesc),
        .cfg        (cfg_q),
        .start_addr (start_q),
        .count      (count_q),
        .next_ptr   (next_q)
    );

    dma_flow_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .start       (fstart),
        .abort       (fabort),
        .start_ptr   (fptr),
        .with_ndp    (flist),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .done        (fdone),
        .desc        (fdesc),
        .ptr_after   (fptr_after)
    );

    dma_flow_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cfg_wr          (cfg_wr),
        .cfg_wr_val      (cfg_wr_val),
        .act_cfg         (cfg_q),
        .start_addr      (start_q),
        .count           (count_q),
        .next_ptr        (next_q),
        .unit_done       (unit_done),
        .fetch_done      (fdone),
        .fd_start        (fdesc.start),
        .fd_count        (fdesc.count),
        .fd_en           (fdesc.cfg.en),
        .fetch_ptr_after (fptr_after),
        .fetch_start     (fstart),
        .fetch_abort     (fabort),
        .fetch_ptr       (fptr),
        .fetch_list      (flist),
        .run             (run),
        .unit_load       (unit_load),
        .cur_addr        (cur_addr),
        .cur_count       (cur_count),
        .irq             (irq)
    );
endmodule

// File: tb/dma_flow_seq_bench.sv
`timescale 1ns/1ps
module dma_flow_seq_bench;
    import dma_flow_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_sel;
    logic [31:0] reg_wr_data;
    logic        unit_done;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack;
    logic [15:0] mem_rd_data;
    logic        run;
    logic        unit_load;
    logic [31:0] cur_addr;
    logic [15:0] cur_count;
    logic        irq;

    always #2 clk = ~clk;

    dma_flow_seq u_dma_flow_seq (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .unit_done(unit_done), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .run(run), .unit_load(unit_load), .cur_addr(cur_addr), .cur_count(cur_count),
        .irq(irq)
    );

    // memory model: one wait cycle before each acknowledge
    logic [15:0] mem [256];
    logic        ack_q;
    assign mem_rd_ack  = ack_q;
    assign mem_rd_data = mem[mem_rd_addr[8:1]];
    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= mem_rd_req && !ack_q;
    end

    typedef struct packed { logic [31:0] a; logic [15:0] c; } unit_t;
    unit_t       unit_q[$];
    logic [31:0] rd_q[$];
    int          checks = 0;
    int          errors = 0;
    int          irq_seen = 0;
    int          req_cycles = 0;
    string       tag_now = "R2";
    string       tag_rd = "R6";
    bit          hold_prev = 1'b0;
    logic [31:0] hold_addr = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares loads and read addresses against the scoreboard
    always @(negedge clk) begin : mon
        unit_t       e;
        logic [31:0] ra;
        if (!rst) begin
            if (irq) irq_seen++;
            if (mem_rd_req) req_cycles++;
            if (unit_load) begin
                if (unit_q.size() == 0) begin
                    check(1'b0, {tag_now, " unexpected load"}, cur_addr, 32'h0);
                end else begin
                    e = unit_q.pop_front();
                    check(cur_addr == e.a, {tag_now, " load address"}, cur_addr, e.a);
                    check(cur_count == e.c, {tag_now, " load count"},
                          {16'h0, cur_count}, {16'h0, e.c});
                end
            end
            if (mem_rd_req && mem_rd_ack) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, {tag_rd, " unexpected read"}, mem_rd_addr, 32'h0);
                end else begin
                    ra = rd_q.pop_front();
                    check(mem_rd_addr == ra, {tag_rd, " read address"}, mem_rd_addr, ra);
                end
            end
            if (hold_prev && mem_rd_req)
                check(mem_rd_addr == hold_addr, "R9 address held during wait",
                      mem_rd_addr, hold_addr);
            hold_prev = mem_rd_req && !mem_rd_ack;
            hold_addr = mem_rd_addr;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
    endtask

    task automatic expect_unit(input logic [31:0] a, input logic [15:0] c);
        unit_t e;
        e.a = a;
        e.c = c;
        unit_q.push_back(e);
    endtask

    task automatic expect_reads(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) rd_q.push_back(base + 32'(2 * i));
    endtask

    task automatic put(input logic [31:0] a, input logic [15:0] d);
        mem[a[8:1]] = d;
    endtask

    task automatic drain(input string tag);
        int n;
        n = 0;
        while ((unit_q.size() != 0 || rd_q.size() != 0) && n < 300) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(unit_q.size() == 0 && rd_q.size() == 0, {tag, " scoreboard drained"},
              32'(unit_q.size() + rd_q.size()), 32'h0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
        finish_run();
    end

    initial begin : driver
        int irq_base;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0; unit_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!run && !irq && !unit_load && !mem_rd_req, "R1 reset outputs low",
              {28'h0, run, irq, unit_load, mem_rd_req}, 32'h0);
        check(cur_addr == 0 && cur_count == 0, "R1 reset current registers", cur_addr, 32'h0);

        // R11: done while idle is ignored
        pulse_done();
        check(!irq, "R11 no irq when idle", {31'h0, irq}, 32'h0);
        repeat (2) @(negedge clk);
        check(!run && irq_seen == 0 && req_cycles == 0, "R11 idle ignores done",
              32'(irq_seen + req_cycles), 32'h0);

        // stop flow, restart
        tag_now = "R2 launch";
        wr(SEL_START, 32'h0000_1000);
        wr(SEL_COUNT, 32'h20);
        expect_unit(32'h0000_1000, 16'h20);
        wr(SEL_CFG, 32'h3);
        drain("R2");
        check(run, "R2 run after launch", {31'h0, run}, 32'h1);
        pulse_done();
        check(irq, "R3 irq after done", {31'h0, irq}, 32'h1);
        check(!run, "R4 stop drops run", {31'h0, run}, 32'h0);
        @(negedge clk);
        check(!irq, "R3 irq lasts one cycle", {31'h0, irq}, 32'h0);
        pulse_done();
        check(!irq && !run, "R4 paused ignores done", {30'h0, irq, run}, 32'h0);
        tag_now = "R4 restart";
        wr(SEL_START, 32'h0000_2000);
        wr(SEL_COUNT, 32'h30);
        expect_unit(32'h0000_2000, 16'h30);
        wr(SEL_CFG, 32'h1);
        drain("R4");
        check(run, "R4 restart raises run", {31'h0, run}, 32'h1);
        pulse_done();
        check(!irq, "R3 irq gated by enable bit", {31'h0, irq}, 32'h0);
        check(!run, "R4 stop again", {31'h0, run}, 32'h0);

        // reserved flow 5 acts as stop
        tag_now = "R10 launch";
        expect_unit(32'h0000_2000, 16'h30);
        wr(SEL_CFG, 32'h17);
        drain("R10");
        pulse_done();
        check(!run && irq, "R10 reserved flow stops", {30'h0, run, irq}, 32'h1);

        // circular reload
        tag_now = "R5 reload";
        wr(SEL_START, 32'h0000_3000);
        wr(SEL_COUNT, 32'h10);
        expect_unit(32'h0000_3000, 16'h10);
        wr(SEL_CFG, 32'h7);
        drain("R5");
        for (int k = 0; k < 3; k++) begin
            expect_unit(32'h0000_3000, 16'h10);
            pulse_done();
            check(unit_load && run && irq && cur_addr == 32'h0000_3000,
                  "R5 zero-gap reload", cur_addr, 32'h0000_3000);
        end
        wr(SEL_START, 32'h0000_3400);
        expect_unit(32'h0000_3400, 16'h10);
        pulse_done();
        check(unit_load && cur_addr == 32'h0000_3400, "R5 reload from parameter register",
              cur_addr, 32'h0000_3400);
        check(req_cycles == 0, "R5 no descriptor reads", 32'(req_cycles), 32'h0);
        wr(SEL_CFG, 32'h0);
        check(!run, "R5 enable clear halts", {31'h0, run}, 32'h0);
        drain("R5 end");

        // descriptor array
        put(32'h40, 16'h6000); put(32'h42, 16'h0000); put(32'h44, 16'h0013); put(32'h46, 16'h0004);
        put(32'h48, 16'h6100); put(32'h4A, 16'h0000); put(32'h4C, 16'h0013); put(32'h4E, 16'h0005);
        put(32'h50, 16'h6200); put(32'h52, 16'h0000); put(32'h54, 16'h0003); put(32'h56, 16'h0006);
        tag_now = "R6 array";
        tag_rd  = "R6 array";
        wr(SEL_NEXT, 32'h0000_0040);
        wr(SEL_START, 32'h0000_5000);
        wr(SEL_COUNT, 32'h8);
        expect_unit(32'h0000_5000, 16'h8);
        wr(SEL_CFG, 32'h13);
        drain("R6 launch");
        for (int k = 0; k < 3; k++) begin
            expect_reads(32'h40 + 32'(8 * k), 4);
            expect_unit(32'h0000_6000 + 32'(256 * k), 16'(4 + k));
            pulse_done();
            drain("R6 descriptor");
            check(run, "R6 running after descriptor", {31'h0, run}, 32'h1);
        end
        irq_base = irq_seen;
        pulse_done();
        check(!run && irq, "R8 fetched flow switches to stop", {30'h0, run, irq}, 32'h1);

        // page-local list
        put(32'h100, 16'h0120); put(32'h102, 16'h8000); put(32'h104, 16'h0009);
        put(32'h106, 16'h001B); put(32'h108, 16'h0007);
        put(32'h120, 16'h0140); put(32'h122, 16'h8100); put(32'h124, 16'h0009);
        put(32'h126, 16'h001B); put(32'h128, 16'h0009);
        put(32'h140, 16'hFFFF); put(32'h142, 16'h8200); put(32'h144, 16'h0009);
        put(32'h146, 16'h0000); put(32'h148, 16'h0002);
        tag_now = "R7 list";
        tag_rd  = "R7 list";
        wr(SEL_NEXT, 32'h0005_0100);
        wr(SEL_START, 32'h0000_7000);
        wr(SEL_COUNT, 32'h3);
        expect_unit(32'h0000_7000, 16'h3);
        wr(SEL_CFG, 32'h1B);
        drain("R7 launch");
        expect_reads(32'h0005_0100, 5);
        expect_unit(32'h0009_8000, 16'h7);
        pulse_done();
        drain("R7 first");
        check(run, "R7 running after first", {31'h0, run}, 32'h1);
        expect_reads(32'h0005_0120, 5);
        expect_unit(32'h0009_8100, 16'h9);
        pulse_done();
        drain("R7 second");
        expect_reads(32'h0005_0140, 5);
        pulse_done();
        drain("R7 third");
        repeat (3) @(negedge clk);
        check(!run && !unit_load, "R8 fetched enable clear stops", {31'h0, run}, 32'h0);
        check(irq_seen == irq_base + 4, "R3 irq count over chains",
              32'(irq_seen), 32'(irq_base + 4));
        check(unit_q.size() == 0 && rd_q.size() == 0, "R8 no stray work",
              32'(unit_q.size() + rd_q.size()), 32'h0);
        finish_run();
    end
endmodule